// File: doc/BRIEF.md
# DDR Input Capture with Rate-Halving FIFO

This block receives one double-data-rate input line whose source also sends a strobe clock. One register samples the line on each rising strobe edge and another samples it on each falling edge. An alignment register, clocked on the rising edge, then holds each rising/falling sample couple as a two-bit pair. The pairs go into a small dual-clock FIFO that is written on the strobe clock and read on a system clock. In half-rate mode the system clock runs at half the strobe rate and each read delivers two pairs as one four-bit word.

Either stage can be bypassed. The strobe can be inverted, which memory reads of the DDR2/DDR3 kind need. Each clock domain has its own active-high asynchronous reset. After reset the read side holds its output until a set number of pairs has been stored. This gives the read side margin against phase drift between the two clocks.

The read side is a four-state machine. `RD_IDLE` is the state held in reset, and it always moves to `RD_FILL`. `RD_FILL` waits for the start level and then moves to `RD_RUN`. `RD_RUN` pops one pair (full rate) or two pairs (half rate) per read clock. If too few pairs are stored it moves to `RD_WAIT`. `RD_WAIT` goes back to `RD_RUN` once enough pairs are stored again.

Top module: `ddr_rx_top`

## Requirements
- R1: A pair consists of the sample taken at a rising capture edge (pair bit 0) and the sample taken at the following falling edge (pair bit 1). Pairs leave the block in capture order, starting with the first rising edge after the capture reset is released.
- R2: In full-rate mode (`cfg_half_rate`=0) each read clock with `dout_valid` high delivers one pair on `dout[1:0]`, with `dout[3:2]`=0. No pair is lost or repeated.
- R3: In half-rate mode (`cfg_half_rate`=1) each valid output word holds two consecutive pairs. The earlier pair is on `dout[1:0]` and the later pair is on `dout[3:2]`.
- R4: With `cfg_strobe_inv`=1 the capture edges swap. The falling edge of `strb_clk` acts as the rising capture edge, and the rising edge acts as the falling capture edge.
- R5: With `cfg_capture_bypass`=1 the DDR registers are skipped. Each rising capture edge stores the pair {din, din} sampled at that edge.
- R6: With `cfg_fifo_bypass`=1 the output is `dout` = {2'b00, aligned pair}. It changes at the rising capture edge that follows the pair's falling sample. `dout_valid` is high once aligned pairs exist.
- R7: After reset, `dout_valid` stays low until at least START_LEVEL pairs have been written into the FIFO.
- R8: The read side never pops more pairs than are stored. While it is starved, `dout_valid` is low.
- R9: While `sys_rst` is high and the FIFO is not bypassed, `dout` is 0 and `dout_valid` is 0.
- R10: The FIFO never holds more than FIFO_DEPTH pairs. Each pointer that crosses between the clock domains changes by at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| strb_clk | input | 1 | Source-synchronous strobe used as the capture and FIFO write clock |
| strb_rst | input | 1 | Active-high asynchronous reset of the capture domain |
| sys_clk | input | 1 | System read clock (half the strobe rate in half-rate mode) |
| sys_rst | input | 1 | Active-high asynchronous reset of the read domain |
| cfg_strobe_inv | input | 1 | Invert the strobe before it is used for capture |
| cfg_capture_bypass | input | 1 | Skip the DDR registers; store {din, din} sampled on each rising capture edge |
| cfg_fifo_bypass | input | 1 | Skip the FIFO; drive the aligned pair straight to the output |
| cfg_half_rate | input | 1 | 1: four-bit output holding two pairs; 0: one pair per read |
| din | input | 1 | Double-data-rate data line |
| dout | output | 4 | Output word |
| dout_valid | output | 1 | Output word is valid |

## Verification
The assertions check four things on every clock. The FIFO occupancy seen from either side stays within its depth. Each Gray pointer changes by at most one bit per clock of its domain. The read machine stays in `RD_FILL` below the start level. Full-rate words keep their upper pair at zero. The scoreboard scenarios cover the rest: pair ordering and bit order, half-rate packing, the effect of strobe inversion, both bypass paths, and the amount of data stored before the first output word. All of these depend on the data pattern that the bench drives on the line.

// File: rtl/ddr_rx_pkg.sv
package ddr_rx_pkg;
    localparam int PAIR_W = 2;
    localparam int WORD_W = 2 * PAIR_W;

    typedef logic [PAIR_W-1:0] pair_t;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_FILL = 2'd1,
        RD_RUN  = 2'd2,
        RD_WAIT = 2'd3
    } rd_state_t;
endpackage

// File: rtl/ddr_pair_capture.sv
module ddr_pair_capture
    import ddr_rx_pkg::*;
(
    input  logic  cap_clk,
    input  logic  cap_rst,
    input  logic  bypass,
    input  logic  din,
    output pair_t pair,
    output logic  pair_vld
);
    logic  rise_q;
    logic  fall_q;
    logic  armed_q;
    logic  align_vld_q;
    pair_t align_q;

    // rising-edge sample
    always_ff @(posedge cap_clk or posedge cap_rst) begin
        if (cap_rst) begin
            rise_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            rise_q  <= din;
            armed_q <= 1'b1;
        end
    end

    // falling-edge sample
    always_ff @(negedge cap_clk or posedge cap_rst) begin
        if (cap_rst) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= din;
        end
    end

    // alignment onto the rising edge: both bits of one strobe cycle together
    always_ff @(posedge cap_clk or posedge cap_rst) begin
        if (cap_rst) begin
            align_q     <= '0;
            align_vld_q <= 1'b0;
        end else begin
            align_q     <= {fall_q, rise_q};
            align_vld_q <= armed_q;
        end
    end

    always_comb begin
        if (bypass) begin
            pair     = {din, din};
            pair_vld = ~cap_rst;
        end else begin
            pair     = align_q;
            pair_vld = align_vld_q;
        end
    end
endmodule

// File: rtl/ptr_sync.sv
module ptr_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], d};
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ddr_rate_fifo.sv
module ddr_rate_fifo
    import ddr_rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int START_LEVEL = 6
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  pair_t             wr_pair,
    input  logic              wr_vld,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              half_rate,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_vld
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // read pointer as published to the write side: in half rate it counts pairs of entries
    function automatic logic [PW-1:0] publish(input logic [PW-1:0] b, input logic hr);
        return hr ? to_gray({1'b0, b[PW-1:1]}) : to_gray(b);
    endfunction

    pair_t mem [DEPTH];

    // ---------------- write domain ----------------
    logic [PW-1:0] wr_bin_q, wr_gray_q;
    logic [PW-1:0] rd_gray_sync_w, rd_dec_w, rd_ptr_w, wr_level;
    logic          wr_ok;

    ptr_sync #(.W(PW), .STAGES(2)) u_rd_to_wr (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rd_gray_q),
        .q   (rd_gray_sync_w)
    );

    always_comb begin
        rd_dec_w = from_gray(rd_gray_sync_w);
        rd_ptr_w = half_rate ? {rd_dec_w[PW-2:0], 1'b0} : rd_dec_w;
        wr_level = wr_bin_q - rd_ptr_w;
        wr_ok    = wr_vld && (wr_level < PW'(DEPTH));
    end

    always_ff @(posedge wr_clk or posedge wr_rst) begin
        if (wr_rst) begin
            wr_bin_q  <= '0;
            wr_gray_q <= '0;
        end else if (wr_ok) begin
            wr_bin_q  <= wr_bin_q + PW'(1);
            wr_gray_q <= to_gray(wr_bin_q + PW'(1));
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_ok) begin
            mem[wr_bin_q[AW-1:0]] <= wr_pair;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_level <= PW'(DEPTH)); // R10
    AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wr_gray_q ^ $past(wr_gray_q)) <= 1); // R10

    // ---------------- read domain ----------------
    rd_state_t         state_q, state_d;
    logic [PW-1:0]     rd_bin_q, rd_gray_q;
    logic [PW-1:0]     wr_gray_sync_r, rd_level, need;
    logic [AW-1:0]     idx0, idx1;
    logic              pop;
    logic [WORD_W-1:0] data_q;
    logic              vld_q;

    ptr_sync #(.W(PW), .STAGES(2)) u_wr_to_rd (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wr_gray_q),
        .q   (wr_gray_sync_r)
    );

    always_comb begin
        rd_level = from_gray(wr_gray_sync_r) - rd_bin_q;
        need     = half_rate ? PW'(2) : PW'(1);
        idx0     = rd_bin_q[AW-1:0];
        idx1     = idx0 + AW'(1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: state_d = RD_FILL;
            RD_FILL: if (rd_level >= PW'(START_LEVEL)) state_d = RD_RUN;
            RD_RUN:  if (rd_level < need) state_d = RD_WAIT;
            RD_WAIT: if (rd_level >= need) state_d = RD_RUN;
        endcase
    end

    // state register
    always_ff @(posedge rd_clk or posedge rd_rst) begin
        if (rd_rst) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output and pointer process
    assign pop = (state_q == RD_RUN) && (rd_level >= need);

    always_ff @(posedge rd_clk or posedge rd_rst) begin
        if (rd_rst) begin
            rd_bin_q  <= '0;
            rd_gray_q <= '0;
            data_q    <= '0;
            vld_q     <= 1'b0;
        end else begin
            vld_q <= pop;
            if (pop) begin
                rd_bin_q  <= rd_bin_q + need;
                rd_gray_q <= publish(rd_bin_q + need, half_rate);
                data_q    <= half_rate ? {mem[idx1], mem[idx0]} : {{PAIR_W{1'b0}}, mem[idx0]};
            end
        end
    end

    assign rd_data = data_q;
    assign rd_vld  = vld_q;

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_level <= PW'(DEPTH)); // R8
    AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rd_gray_q ^ $past(rd_gray_q)) <= 1); // R10
    AST_FILL_HOLD: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (state_q == RD_FILL && rd_level < PW'(START_LEVEL)) |=> state_q == RD_FILL); // R7
    AST_HALF_EVEN: assert property (@(posedge rd_clk) disable iff (rd_rst)
        half_rate |-> rd_bin_q[0] == 1'b0); // R3
endmodule

// File: rtl/ddr_rx_top.sv
module ddr_rx_top
    import ddr_rx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int START_LEVEL = 6
) (
    input  logic              strb_clk,
    input  logic              strb_rst,
    input  logic              sys_clk,
    input  logic              sys_rst,
    input  logic              cfg_strobe_inv,
    input  logic              cfg_capture_bypass,
    input  logic              cfg_fifo_bypass,
    input  logic              cfg_half_rate,
    input  logic              din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_valid
);
    logic              cap_clk;
    pair_t             cap_pair;
    logic              cap_vld;
    logic [WORD_W-1:0] fifo_data;
    logic              fifo_vld;

    assign cap_clk = strb_clk ^ cfg_strobe_inv;

    ddr_pair_capture u_capture (
        .cap_clk  (cap_clk),
        .cap_rst  (strb_rst),
        .bypass   (cfg_capture_bypass),
        .din      (din),
        .pair     (cap_pair),
        .pair_vld (cap_vld)
    );

    ddr_rate_fifo #(
        .DEPTH       (FIFO_DEPTH),
        .START_LEVEL (START_LEVEL)
    ) u_fifo (
        .wr_clk    (cap_clk),
        .wr_rst    (strb_rst),
        .wr_pair   (cap_pair),
        .wr_vld    (cap_vld),
        .rd_clk    (sys_clk),
        .rd_rst    (sys_rst),
        .half_rate (cfg_half_rate),
        .rd_data   (fifo_data),
        .rd_vld    (fifo_vld)
    );

    always_comb begin
        if (cfg_fifo_bypass) begin
            dout       = {{PAIR_W{1'b0}}, cap_pair};
            dout_valid = cap_vld;
        end else begin
            dout       = fifo_data;
            dout_valid = fifo_vld;
        end
    end

    AST_FULL_RATE_UPPER: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (dout_valid && !cfg_half_rate && !cfg_fifo_bypass) |-> dout[WORD_W-1:PAIR_W] == '0); // R2
endmodule

// File: tb/tb_ddr_rx_top.sv
`timescale 1ns/1ps
module tb_ddr_rx_top;
    import ddr_rx_pkg::*;

    localparam int DEPTH = 16;
    localparam int START = 6;

    logic strb_clk = 1'b0;
    logic sys_clk  = 1'b0;
    logic strb_rst = 1'b1;
    logic sys_rst  = 1'b1;
    logic inv = 1'b0, cbyp = 1'b0, fbyp = 1'b0, half = 1'b0;
    logic din = 1'b0;
    logic [3:0] dout;
    logic       dout_valid;

    int    sys_half = 5;
    int    n_checks = 0;
    int    n_fail   = 0;
    pair_t exp_q[$];
    logic  mon_en     = 1'b0;
    logic  first_seen = 1'b0;
    int    mon_limit  = 0;
    int    mon_pairs  = 0;
    string cur_tag    = "R1";

    ddr_rx_top #(.FIFO_DEPTH(DEPTH), .START_LEVEL(START)) dut (
        .strb_clk           (strb_clk),
        .strb_rst           (strb_rst),
        .sys_clk            (sys_clk),
        .sys_rst            (sys_rst),
        .cfg_strobe_inv     (inv),
        .cfg_capture_bypass (cbyp),
        .cfg_fifo_bypass    (fbyp),
        .cfg_half_rate      (half),
        .din                (din),
        .dout               (dout),
        .dout_valid         (dout_valid)
    );

    always #5 strb_clk = ~strb_clk;
    initial begin
        #3;
        forever #(sys_half) sys_clk = ~sys_clk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic eff_rise();
        if (inv) @(negedge strb_clk); else @(posedge strb_clk);
    endtask

    task automatic eff_fall();
        if (inv) @(posedge strb_clk); else @(negedge strb_clk);
    endtask

    // monitor: pops expected pairs and compares with the output word
    always @(negedge sys_clk) begin
        if (mon_en && dout_valid) begin
            if (!first_seen) begin
                first_seen = 1'b1;
                // R7: START pairs written, plus two more already driven by then
                check(exp_q.size() >= START + 2, "R7", exp_q.size(), START + 2);
            end
            if (half) begin
                if (exp_q.size() < 2) begin
                    check(1'b0, "R8", exp_q.size(), 2); // output without stored data
                end else begin
                    pair_t p0, p1;
                    p0 = exp_q.pop_front();
                    p1 = exp_q.pop_front();
                    check(dout == {p1, p0}, {cur_tag, " R3"}, dout, {p1, p0});
                    mon_pairs += 2;
                end
            end else begin
                if (exp_q.size() < 1) begin
                    check(1'b0, "R8", 0, 1);
                end else begin
                    pair_t p0;
                    p0 = exp_q.pop_front();
                    // R2 and R10: a lost or repeated pair shows as a mismatch
                    check(dout == {2'b00, p0}, {cur_tag, " R2"}, dout, {2'b00, p0});
                    mon_pairs += 1;
                end
            end
            if (mon_pairs >= mon_limit) mon_en = 1'b0;
        end
    end

    // driver: runs one scenario, pushes expected pairs into the scoreboard
    task automatic run(input bit i_inv, input bit cb, input bit fb, input bit hf,
                       input string tag, input int n);
        pair_t pat[200];
        strb_rst = 1'b1;
        sys_rst  = 1'b1;
        mon_en   = 1'b0;
        repeat (4) @(posedge strb_clk);
        inv = i_inv; cbyp = cb; fbyp = fb; half = hf;
        sys_half = hf ? 10 : 5;
        exp_q.delete();
        first_seen = 1'b0;
        mon_pairs  = 0;
        mon_limit  = n - 14;
        cur_tag    = tag;
        for (int i = 0; i < n; i++) pat[i] = pair_t'($urandom);
        repeat (6) @(posedge strb_clk);
        #1;
        if (!fb) begin
            check(dout_valid == 1'b0, "R9", dout_valid, 0);
            check(dout == 4'h0, "R9", dout, 0);
        end
        eff_rise();
        #2;
        din = pat[0][0];
        if (!fb) begin
            exp_q.push_back(cb ? {pat[0][0], pat[0][0]} : pat[0]);
            mon_en = 1'b1;
        end
        strb_rst = 1'b0;
        sys_rst  = 1'b0;
        for (int i = 0; i < n; i++) begin
            eff_rise();
            if (fb && i > 0) begin
                #1;
                check(dout == {2'b00, pat[i-1]} && dout_valid, "R6", dout, {2'b00, pat[i-1]});
                #1;
            end else begin
                #2;
            end
            din = pat[i][1];
            eff_fall();
            #2;
            if (i + 1 < n) begin
                din = pat[i+1][0];
                if (!fb) exp_q.push_back(cb ? {pat[i+1][0], pat[i+1][0]} : pat[i+1]);
            end
        end
        if (!fb) begin
            for (int k = 0; k < 300; k++) begin
                if (!mon_en) break;
                @(posedge strb_clk);
            end
            check(!mon_en, {tag, " R8"}, mon_pairs, mon_limit);
        end
    endtask

    initial begin
        run(1'b0, 1'b0, 1'b0, 1'b0, "R1", 60);  // full rate, normal capture
        run(1'b0, 1'b0, 1'b0, 1'b1, "R3", 60);  // half rate packing
        run(1'b1, 1'b0, 1'b0, 1'b0, "R4", 60);  // inverted strobe, full rate
        run(1'b0, 1'b1, 1'b0, 1'b0, "R5", 40);  // capture bypass
        run(1'b0, 1'b0, 1'b1, 1'b0, "R6", 30);  // FIFO bypass
        run(1'b1, 1'b0, 1'b0, 1'b1, "R4", 40);  // inverted strobe, half rate
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule